// File: doc/BRIEF.md
# Interrupt Routing Table Register Window

This block is the software-facing register file of an I/O interrupt controller. Software reaches all of its state through two locations. A select register at device offset 0x00 holds the index of an internal register. A 32-bit data window at offset 0x10 reads or writes the internal register that the select value names.

The internal registers are:
- an identification register;
- a read-only version register;
- an arbitration register that mirrors the identification value;
- one 64-bit routing entry per interrupt input pin, reached as two 32-bit halves.

The fields of every routing entry are brought out on flat ports for the servicing logic. The servicing logic can set an entry's remote-IRR bit through a per-pin strobe.

The block raises two kinds of one-cycle event for the servicing logic:
- a mask-change event, when a window write flips an entry's mask bit;
- a service request, when a table write lands on a pin whose request line is high.

The bus is a simple valid/ready request channel. Ready is always high. A read returns its data one cycle after it is accepted.

Top module: `irq_win_regs`

## Requirements
- R1: After synchronous reset, every entry has its mask bit (bit 16) set and all other entry bits cleared. The select register and the 4-bit identification value read 0. No response, mask-change event or service request is active.
- R2: A 4- or 8-byte write to offset 0x00 stores data bits 31:0 in the select register, and a read of offset 0x00 returns it. Reads of any offset other than 0x00 and 0x10 return 0, and writes to such offsets change nothing. A window read with a select value of 0x03 to 0x0F returns 0.
- R3: With select 0x01, a window read returns (pin count − 1) in bits 23:16 and the version constant in bits 7:0, with all other bits 0. Window writes with select 0x01 change nothing.
- R4: With select 0x00, a window write stores data bits 27:24 as the identification value. Window reads with select 0x00 or 0x02 return that value in bits 27:24 and 0 elsewhere. Window writes with select 0x02 change nothing.
- R5: A select value S ≥ 0x10 addresses entry (S − 0x10) >> 1. S bit 0 picks the upper half (1) or the lower half (0). A write replaces that half and a read returns it. The entry fields come out on the ports as follows: vector bits 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-IRR 14, trigger mode 15, mask 16, destination 63:56.
- R6: A window access whose entry index is at or beyond the pin count has no effect on a write and returns 0 on a read.
- R7: A lower-half write forces that entry's remote-IRR bit to 0, whatever data bit 14 holds. An upper-half write leaves remote-IRR unchanged. A pulse on the pin's remote-IRR set input sets the bit, unless a lower-half write to the same pin lands in the same cycle.
- R8: When a table write changes an entry's mask bit, a mask-change event is raised for exactly the next cycle, carrying the pin index and the new mask value. No event is raised when the mask bit does not change.
- R9: When a table write lands on a pin whose request input is high in the write cycle, a service request carrying that pin index is raised for exactly the next cycle. It is raised for either half and also when the entry's data is unchanged.
- R10: Writes are accepted only with a size of 4 or 8 bytes. Writes of any other size change nothing. Write data bits 63:32 are never used.
- R11: Ready is always high. Each accepted read produces exactly one response, in the following cycle, with the data that was selected at the time of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the device |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data (bits 31:0 used) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pend | input | NPINS | Per-pin request lines from the servicing logic |
| rirr_set | input | NPINS | Per-pin strobe that sets remote-IRR |
| ent_vector | output | NPINS*8 | Vector field of each entry |
| ent_dlvmode | output | NPINS*3 | Delivery mode field of each entry |
| ent_dstmode | output | NPINS | Destination mode bit of each entry |
| ent_polarity | output | NPINS | Polarity bit of each entry |
| ent_rirr | output | NPINS | Remote-IRR bit of each entry |
| ent_trigger | output | NPINS | Trigger mode bit of each entry |
| ent_mask | output | NPINS | Mask bit of each entry |
| ent_dest | output | NPINS*8 | Destination field of each entry |
| mask_evt_valid | output | 1 | One-cycle mask-change event |
| mask_evt_pin | output | IDXW | Pin whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| svc_valid | output | 1 | One-cycle service request |
| svc_pin | output | IDXW | Pin to be serviced |

## Verification
The bench targets these corner cases:
- **Hidden clear of remote-IRR.** A lower-half write must clear remote-IRR even when data bit 14 is 1, and an upper-half write must leave a set bit alone. A design that stored bit 14 from the data, or that cleared the bit on every write, shows the wrong remote-IRR port value.
- **First index past the table.** The bench writes and reads the entry at index equal to the pin count. A design that wrapped or truncated the index would corrupt a low entry, or read back non-zero data.
- **Rejected sizes.** Writes of size 1 and 2 must be dropped, and an 8-byte write must use only its low word. A design that got this wrong would change the select or entry contents.
- **Event timing.** A rewrite of the mask bit to its current value must raise no event. A service request must follow a write whose data does not change the entry. A design that compared the wrong state, or gated the request on a data change, misses an event or raises an extra one in that cycle.

// File: rtl/irq_win_pkg.sv
`timescale 1ns/1ps
// Package irq_win_pkg
// Shared constants for the interrupt routing register window: device offsets,
// select codes and the bit positions of routing-entry fields.
package irq_win_pkg;
    // Device byte offsets
    localparam logic [7:0]  OFS_SELECT = 8'h00;
    localparam logic [7:0]  OFS_WINDOW = 8'h10;

    // Select codes below the table
    localparam logic [31:0] SEL_IDENT  = 32'h0000_0000;
    localparam logic [31:0] SEL_VERS   = 32'h0000_0001;
    localparam logic [31:0] SEL_ARBIT  = 32'h0000_0002;
    localparam logic [31:0] SEL_TABLE  = 32'h0000_0010;

    // Entry field positions (neighbouring logic decodes these)
    localparam int VEC_LO   = 0;
    localparam int DLV_LO   = 8;
    localparam int DSTM_BIT = 11;
    localparam int POL_BIT  = 13;
    localparam int RIRR_BIT = 14;
    localparam int TRIG_BIT = 15;
    localparam int MASK_BIT = 16;
    localparam int DEST_LO  = 56;

    // Entry value after reset: masked, everything else zero
    localparam logic [63:0] ENTRY_RESET = 64'h1 << MASK_BIT;
endpackage

// File: rtl/irq_win_decode.sv
`timescale 1ns/1ps
// Module irq_win_decode
// Purely combinational decode of one bus request against the current select
// value. Produces write strobes for the select register, the identification
// register and the routing table, and the table index / half for reads.
// Assumes one request per cycle and that offsets are already device-relative.
module irq_win_decode
    import irq_win_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDXW  = 5
) (
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [7:0]      req_addr,
    input  logic [3:0]      req_size,
    input  logic [31:0]     sel_q,
    output logic            off_sel,
    output logic            off_win,
    output logic            sel_wr,
    output logic            ident_wr,
    output logic            tbl_hit,
    output logic            tbl_wr,
    output logic            tbl_hi,
    output logic [IDXW-1:0] tbl_idx
);
    logic        size_ok;
    logic        wr_ok;
    logic        in_table;
    logic [31:0] rel_sel;
    logic [31:0] idx_full;

    // Offset, size and select decode for the current request
    always_comb begin
        size_ok  = (req_size == 4'd4) || (req_size == 4'd8);
        wr_ok    = req_valid && req_write && size_ok;
        off_sel  = (req_addr == OFS_SELECT);
        off_win  = (req_addr == OFS_WINDOW);
        sel_wr   = wr_ok && off_sel;
        ident_wr = wr_ok && off_win && (sel_q == SEL_IDENT);
        in_table = (sel_q >= SEL_TABLE);
        rel_sel  = sel_q - SEL_TABLE;
        idx_full = rel_sel >> 1;
        tbl_hit  = in_table && (idx_full < 32'(NPINS));
        tbl_idx  = idx_full[IDXW-1:0];
        tbl_hi   = sel_q[0];
        tbl_wr   = wr_ok && off_win && tbl_hit;
    end
endmodule

// File: rtl/irq_win_entry.sv
`timescale 1ns/1ps
// Module irq_win_entry
// One 64-bit routing entry. Software writes replace a 32-bit half; a lower
// half write always clears remote-IRR. The servicing logic may set
// remote-IRR through a strobe; a same-cycle lower-half write wins.
module irq_win_entry
    import irq_win_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    output logic [63:0] ent
);
    // Entry storage with half writes and remote-IRR handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent <= ENTRY_RESET;
        end else begin
            if (wr_hi) begin
                ent[63:32] <= wdata;
            end
            if (wr_lo) begin
                ent[31:RIRR_BIT+1] <= wdata[31:RIRR_BIT+1];
                ent[RIRR_BIT]      <= 1'b0;
                ent[RIRR_BIT-1:0]  <= wdata[RIRR_BIT-1:0];
            end else if (rirr_set) begin
                ent[RIRR_BIT] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_win_events.sv
`timescale 1ns/1ps
// Module irq_win_events
// Registers the one-cycle mask-change event and service request that follow
// a table write. Compares against the mask value held before the write.
// Assumes tbl_idx is in range whenever tbl_wr is high.
module irq_win_events
    import irq_win_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDXW  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_wr,
    input  logic             tbl_hi,
    input  logic [IDXW-1:0]  tbl_idx,
    input  logic             new_mask,
    input  logic [NPINS-1:0] cur_mask,
    input  logic [NPINS-1:0] pend,
    output logic             mask_evt_valid,
    output logic [IDXW-1:0]  mask_evt_pin,
    output logic             mask_evt_val,
    output logic             svc_valid,
    output logic [IDXW-1:0]  svc_pin
);
    logic mask_flip;
    logic pin_pending;

    // Detect a mask flip and a pending pin for the write in flight
    always_comb begin
        mask_flip   = tbl_wr && !tbl_hi && (cur_mask[tbl_idx] != new_mask);
        pin_pending = tbl_wr && pend[tbl_idx];
    end

    // Mask-change event register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_evt_valid <= 1'b0;
            mask_evt_pin   <= '0;
            mask_evt_val   <= 1'b0;
        end else begin
            mask_evt_valid <= mask_flip;
            if (mask_flip) begin
                mask_evt_pin <= tbl_idx;
                mask_evt_val <= new_mask;
            end
        end
    end

    // Service request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_valid <= 1'b0;
            svc_pin   <= '0;
        end else begin
            svc_valid <= pin_pending;
            if (pin_pending) begin
                svc_pin <= tbl_idx;
            end
        end
    end
endmodule

// File: rtl/irq_win_regs.sv
`timescale 1ns/1ps
// Module irq_win_regs (top)
// Select/window register file of an I/O interrupt controller: select
// register, identification, version, arbitration and one 64-bit routing
// entry per pin. Bus is valid/ready with ready tied high; reads answer one
// cycle after acceptance. Entry fields are exported flat per pin.
// Assumes NPINS <= 256 so the pin count fits the version field.
module irq_win_regs
    import irq_win_pkg::*;
#(
    parameter int          NPINS  = 24,
    parameter logic [7:0]  VER_ID = 8'h20,
    localparam int         IDXW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [7:0]         req_addr,
    input  logic [3:0]         req_size,
    input  logic [63:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    input  logic [NPINS-1:0]   pend,
    input  logic [NPINS-1:0]   rirr_set,
    output logic [NPINS*8-1:0] ent_vector,
    output logic [NPINS*3-1:0] ent_dlvmode,
    output logic [NPINS-1:0]   ent_dstmode,
    output logic [NPINS-1:0]   ent_polarity,
    output logic [NPINS-1:0]   ent_rirr,
    output logic [NPINS-1:0]   ent_trigger,
    output logic [NPINS-1:0]   ent_mask,
    output logic [NPINS*8-1:0] ent_dest,
    output logic               mask_evt_valid,
    output logic [IDXW-1:0]    mask_evt_pin,
    output logic               mask_evt_val,
    output logic               svc_valid,
    output logic [IDXW-1:0]    svc_pin
);
    localparam logic [7:0]  PIN_TOP  = 8'(NPINS - 1);
    localparam logic [31:0] VER_WORD = {8'h00, PIN_TOP, 8'h00, VER_ID};

    logic [31:0]      sel_q;
    logic [3:0]       ident_q;
    logic             off_sel, off_win, sel_wr, ident_wr;
    logic             tbl_hit, tbl_wr, tbl_hi;
    logic [IDXW-1:0]  tbl_idx;
    logic [31:0]      wword;
    logic [NPINS-1:0] wr_lo, wr_hi;
    logic [63:0]      tbl [NPINS];
    logic [31:0]      rd_word;
    logic             rd_take;

    assign req_ready = 1'b1;
    assign wword     = req_wdata[31:0];

    irq_win_decode #(.NPINS(NPINS), .IDXW(IDXW)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .sel_q     (sel_q),
        .off_sel   (off_sel),
        .off_win   (off_win),
        .sel_wr    (sel_wr),
        .ident_wr  (ident_wr),
        .tbl_hit   (tbl_hit),
        .tbl_wr    (tbl_wr),
        .tbl_hi    (tbl_hi),
        .tbl_idx   (tbl_idx)
    );

    // Select register
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= wword;
    end

    // Identification register
    always_ff @(posedge clk) begin
        if (!rst_n)        ident_q <= '0;
        else if (ident_wr) ident_q <= wword[27:24];
    end

    // Per-pin entries, half-write strobes and field export
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign wr_lo[i] = tbl_wr && !tbl_hi && (tbl_idx == IDXW'(i));
        assign wr_hi[i] = tbl_wr &&  tbl_hi && (tbl_idx == IDXW'(i));

        irq_win_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo[i]),
            .wr_hi    (wr_hi[i]),
            .wdata    (wword),
            .rirr_set (rirr_set[i]),
            .ent      (tbl[i])
        );

        assign ent_vector[i*8 +: 8]  = tbl[i][VEC_LO +: 8];
        assign ent_dlvmode[i*3 +: 3] = tbl[i][DLV_LO +: 3];
        assign ent_dstmode[i]        = tbl[i][DSTM_BIT];
        assign ent_polarity[i]       = tbl[i][POL_BIT];
        assign ent_rirr[i]           = tbl[i][RIRR_BIT];
        assign ent_trigger[i]        = tbl[i][TRIG_BIT];
        assign ent_mask[i]           = tbl[i][MASK_BIT];
        assign ent_dest[i*8 +: 8]    = tbl[i][DEST_LO +: 8];
    end

    // Read data selection for the current request
    always_comb begin
        rd_word = '0;
        if (off_sel) begin
            rd_word = sel_q;
        end else if (off_win) begin
            if (sel_q == SEL_IDENT || sel_q == SEL_ARBIT) begin
                rd_word = {4'h0, ident_q, 24'h0};
            end else if (sel_q == SEL_VERS) begin
                rd_word = VER_WORD;
            end else if (tbl_hit) begin
                rd_word = tbl_hi ? tbl[tbl_idx][63:32] : tbl[tbl_idx][31:0];
            end
        end
    end

    assign rd_take = req_valid && !req_write;

    // Single-cycle read response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_take;
            if (rd_take) rsp_rdata <= rd_word;
        end
    end

    irq_win_events #(.NPINS(NPINS), .IDXW(IDXW)) u_evt (
        .clk            (clk),
        .rst_n          (rst_n),
        .tbl_wr         (tbl_wr),
        .tbl_hi         (tbl_hi),
        .tbl_idx        (tbl_idx),
        .new_mask       (wword[MASK_BIT]),
        .cur_mask       (ent_mask),
        .pend           (pend),
        .mask_evt_valid (mask_evt_valid),
        .mask_evt_pin   (mask_evt_pin),
        .mask_evt_val   (mask_evt_val),
        .svc_valid      (svc_valid),
        .svc_pin        (svc_pin)
    );
endmodule

// File: rtl/irq_win_chk.sv
`timescale 1ns/1ps
// Module irq_win_chk
// Property checker for irq_win_regs, attached with bind below.
module irq_win_chk #(
    parameter int NPINS = 24,
    parameter int IDXW  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             rsp_valid,
    input logic [NPINS-1:0] wr_lo,
    input logic [NPINS-1:0] ent_rirr,
    input logic [NPINS-1:0] ent_mask,
    input logic             mask_evt_valid,
    input logic [IDXW-1:0]  mask_evt_pin,
    input logic             mask_evt_val,
    input logic             svc_valid,
    input logic [IDXW-1:0]  svc_pin,
    input logic             ident_wr,
    input logic [3:0]       ident_q
);
    logic [NPINS-1:0] mask_prev;

    // Mask vector one cycle back
    always_ff @(posedge clk) begin
        if (!rst_n) mask_prev <= '1;
        else        mask_prev <= ent_mask;
    end

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R11
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R11
    AST_MASK_EVT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt_valid |-> (ent_mask[mask_evt_pin] == mask_evt_val)); // R8
    AST_MASK_EVT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt_valid |-> (ent_mask[mask_evt_pin] != mask_prev[mask_evt_pin])); // R8
    AST_SVC_PIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> (32'(svc_pin) < 32'(NPINS))); // R9
    AST_IDENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ident_wr |=> $stable(ident_q)); // R4

    for (genvar i = 0; i < NPINS; i++) begin : g_rirr
        AST_LO_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
            wr_lo[i] |=> !ent_rirr[i]); // R7
    end
endmodule

bind irq_win_regs irq_win_chk #(.NPINS(NPINS), .IDXW(IDXW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .rsp_valid      (rsp_valid),
    .wr_lo          (wr_lo),
    .ent_rirr       (ent_rirr),
    .ent_mask       (ent_mask),
    .mask_evt_valid (mask_evt_valid),
    .mask_evt_pin   (mask_evt_pin),
    .mask_evt_val   (mask_evt_val),
    .svc_valid      (svc_valid),
    .svc_pin        (svc_pin),
    .ident_wr       (ident_wr),
    .ident_q        (ident_q)
);

// File: tb/irq_win_regs_tb.sv
`timescale 1ns/1ps
// Bench for irq_win_regs: behavioural reference model updated on each rising
// edge, compared with every output on each falling edge.
module irq_win_regs_tb;
    localparam int NP = 24;
    localparam int IW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]      req_addr = '0;
    logic [3:0]      req_size = '0;
    logic [63:0]     req_wdata = '0;
    logic [NP-1:0]   pend = '0, rirr_set = '0;
    logic            req_ready, rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [NP*8-1:0] ent_vector, ent_dest;
    logic [NP*3-1:0] ent_dlvmode;
    logic [NP-1:0]   ent_dstmode, ent_polarity, ent_rirr, ent_trigger, ent_mask;
    logic            mask_evt_valid, mask_evt_val, svc_valid;
    logic [IW-1:0]   mask_evt_pin, svc_pin;

    irq_win_regs u_dut (.*);

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    bit cmp_en = 0;
    string ctx = "R1";

    // Reference model state
    logic [63:0] m_tbl [NP];
    logic [31:0] m_sel;
    logic [3:0]  m_id;
    bit          e_rsp, e_mev, e_mval, e_svc;
    logic [31:0] e_rdata;
    int          e_mpin, e_spin;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        longint ix;
        if (a == 8'h00) return m_sel;
        if (a != 8'h10) return 32'h0;
        if (m_sel == 0 || m_sel == 2) return {4'h0, m_id, 24'h0};
        if (m_sel == 1) return 32'h0017_0020;
        if (m_sel >= 16) begin
            ix = (longint'(m_sel) - 16) / 2;
            if (ix < NP) return m_sel[0] ? m_tbl[ix][63:32] : m_tbl[ix][31:0];
        end
        return 32'h0;
    endfunction

    // Model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) m_tbl[i] = 64'h0000_0000_0001_0000;
            m_sel = 0; m_id = 0;
            e_rsp = 0; e_mev = 0; e_svc = 0; e_rdata = 0; e_mpin = 0; e_spin = 0; e_mval = 0;
        end else begin
            logic [31:0] d;
            longint ix;
            bit old_m;
            e_rsp = req_valid && !req_write;
            if (e_rsp) e_rdata = m_read(req_addr);
            e_mev = 0; e_svc = 0;
            for (int i = 0; i < NP; i++) if (rirr_set[i]) m_tbl[i][14] = 1'b1;
            if (req_valid && req_write && (req_size == 4 || req_size == 8)) begin
                d = req_wdata[31:0];
                if (req_addr == 8'h00) m_sel = d;
                else if (req_addr == 8'h10) begin
                    if (m_sel == 0) m_id = d[27:24];
                    else if (m_sel >= 16) begin
                        ix = (longint'(m_sel) - 16) / 2;
                        if (ix < NP) begin
                            old_m = m_tbl[ix][16];
                            if (m_sel[0]) m_tbl[ix][63:32] = d;
                            else m_tbl[ix][31:0] = d & ~32'h0000_4000;
                            if (m_tbl[ix][16] != old_m) begin
                                e_mev = 1; e_mpin = int'(ix); e_mval = m_tbl[ix][16];
                            end
                            if (pend[ix]) begin e_svc = 1; e_spin = int'(ix); end
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", tag, ctx, act, exp, $time);
        end
    endtask

    // Comparison of every output on each falling edge
    always @(negedge clk) if (cmp_en) begin
        logic [NP*8-1:0] xv, xd;
        logic [NP*3-1:0] xl;
        logic [NP-1:0]   xdm, xp, xr, xt, xm;
        for (int i = 0; i < NP; i++) begin
            xv[i*8 +: 8] = m_tbl[i][7:0];   xl[i*3 +: 3] = m_tbl[i][10:8];
            xdm[i] = m_tbl[i][11]; xp[i] = m_tbl[i][13]; xr[i] = m_tbl[i][14];
            xt[i] = m_tbl[i][15];  xm[i] = m_tbl[i][16]; xd[i*8 +: 8] = m_tbl[i][63:56];
        end
        chk(req_ready === 1'b1, "R11 ready", 256'(req_ready), 256'(1));
        chk(rsp_valid === e_rsp, "R11 rsp_valid", 256'(rsp_valid), 256'(e_rsp));
        if (e_rsp) chk(rsp_rdata === e_rdata, "read data", 256'(rsp_rdata), 256'(e_rdata));
        chk(ent_vector === xv && ent_dlvmode === xl && ent_dstmode === xdm &&
            ent_polarity === xp && ent_trigger === xt && ent_dest === xd,
            "R5 fields", 256'(ent_vector), 256'(xv));
        chk(ent_mask === xm, "R1/R5 mask", 256'(ent_mask), 256'(xm));
        chk(ent_rirr === xr, "R7 rirr", 256'(ent_rirr), 256'(xr));
        chk(mask_evt_valid === e_mev, "R8 evt valid", 256'(mask_evt_valid), 256'(e_mev));
        if (e_mev) chk(int'(mask_evt_pin) == e_mpin && mask_evt_val === e_mval,
            "R8 evt pin/val", 256'({mask_evt_pin, mask_evt_val}), 256'({e_mpin[IW-1:0], e_mval}));
        chk(svc_valid === e_svc, "R9 svc valid", 256'(svc_valid), 256'(e_svc));
        if (e_svc) chk(int'(svc_pin) == e_spin, "R9 svc pin", 256'(svc_pin), 256'(e_spin));
    end

    task automatic bus(input bit wr, input logic [7:0] a, input logic [3:0] sz, input logic [63:0] d);
        @(negedge clk); #1;
        req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk); #1;
        req_valid = 0;
    endtask

    task automatic tbl_wr(input int pin, input bit hi, input logic [31:0] d);
        bus(1, 8'h00, 4, 64'(32'h10 + 2 * pin + hi));
        bus(1, 8'h10, 4, {32'hDEAD_BEEF, d});
    endtask

    task automatic tbl_rd(input int pin, input bit hi);
        bus(1, 8'h00, 4, 64'(32'h10 + 2 * pin + hi));
        bus(0, 8'h10, 4, 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(posedge clk); cmp_en = 1;   // R1: reset state compared from here
        repeat (2) @(posedge clk);
        @(negedge clk); #1 rst_n = 1;
        ctx = "R2";
        bus(0, 8'h00, 4, 0);
        bus(1, 8'h00, 4, 64'h0000_0001);
        bus(0, 8'h00, 4, 0);
        bus(0, 8'h20, 4, 0);
        bus(1, 8'h20, 4, 64'h1234);         // other offset ignored
        bus(0, 8'h00, 4, 0);
        ctx = "R3";
        bus(0, 8'h10, 4, 0);                // version word
        bus(1, 8'h10, 4, 64'hFFFF_FFFF);
        bus(0, 8'h10, 4, 0);
        ctx = "R4";
        bus(1, 8'h00, 4, 0);
        bus(1, 8'h10, 4, 64'hA500_0000);
        bus(0, 8'h10, 4, 0);
        bus(1, 8'h00, 4, 2);
        bus(0, 8'h10, 4, 0);
        bus(1, 8'h10, 4, 64'h3000_0000);    // arbitration write ignored
        bus(1, 8'h00, 4, 0);
        bus(0, 8'h10, 4, 0);
        ctx = "R2";
        bus(1, 8'h00, 4, 5);
        bus(0, 8'h10, 4, 0);
        ctx = "R5";
        tbl_wr(0, 0, 32'h0000_A9C1);
        tbl_wr(0, 1, 32'h7F00_0000);
        tbl_rd(0, 0); tbl_rd(0, 1);
        tbl_wr(23, 1, 32'hC3FF_FFFF);
        tbl_wr(23, 0, 32'h0001_BFFF);       // mask kept, no event
        tbl_rd(23, 0); tbl_rd(23, 1);
        ctx = "R7";
        @(negedge clk); #1 rirr_set = 24'h000080; @(negedge clk); #1 rirr_set = 0;
        tbl_wr(7, 1, 32'h1100_0000);        // upper half keeps rirr
        tbl_rd(7, 0);
        tbl_wr(7, 0, 32'h0000_4055);        // lower half clears despite bit 14
        tbl_rd(7, 0);
        ctx = "R8";
        tbl_wr(7, 0, 32'h0001_0055);
        tbl_wr(7, 0, 32'h0001_0055);
        ctx = "R9";
        pend = 24'h000008;
        tbl_wr(3, 1, 32'h0);
        tbl_wr(3, 1, 32'h0);
        tbl_wr(4, 1, 32'h0);
        pend = 0;
        ctx = "R6";
        tbl_wr(NP, 0, 32'h0000_0000);
        tbl_rd(NP, 0); tbl_rd(NP, 1);
        bus(1, 8'h00, 4, 64'hFFFF_FFFF);
        bus(1, 8'h10, 4, 64'h0);
        bus(0, 8'h10, 4, 0);
        ctx = "R10";
        bus(1, 8'h00, 4, 64'h10);
        bus(1, 8'h10, 2, 64'h0000_0000);
        bus(1, 8'h10, 1, 64'h0000_0000);
        bus(1, 8'h00, 2, 64'h11);
        bus(1, 8'h10, 8, 64'hFFFF_FFFF_0001_0022);
        tbl_rd(0, 0);
        ctx = "R11";
        for (int k = 0; k < NP; k++) begin
            logic [31:0] d;
            d = 32'h9E37_79B9 * (k + 1);
            pend = 24'h555555 << (k % 2);
            rirr_set = 24'(1) << k;
            tbl_wr(k, k % 2, d);
            rirr_set = 0;
            tbl_rd(k, 0); tbl_rd(k, 1);
        end
        pend = 0;
        repeat (3) @(negedge clk);
        cmp_en = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule